// File: doc/BRIEF.md
# Selectable-Source Event Counter Bank

This block keeps six event counters for a wireless transceiver datapath. Each counter watches one of two qualified event sources. A per-counter bit in a shared source-select register picks between a receive-side source and a transmit/radio-side source. The sources are built inside the block from raw one-cycle status strobes and level flags:

- preamble detects and header-valid strobes;
- frame-check completion and its CRC result;
- the sender-address match, the destination-is-self flag and the data-frame flag;
- a compare of the RSSI against a threshold;
- gain change, AGC lock, TX start, TX done and TX-needs-ACK.

Software reaches the bank through a flat register port. Writes are synchronous, and reads are combinational from a register index. The same port holds three configuration registers: the sender-address target, the RSSI threshold and the source-select word. A write of any value to a counter index clears that counter, and a read returns how many events it has seen since the last clear.

Top module: `evt_counter_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every counter and every configuration register to zero. A read of any index other than 7, 9, 19 and 26..31 returns zero.
- R2: Index 7 holds the 32-bit sender-address target, index 9 the RSSI threshold, and index 19 the 32-bit source-select word. A write stores `wr_data`, and a read returns the stored value. The threshold keeps only the low RSSI_W bits and reads back zero-extended.
- R3: The counter for index 26+i (i = 0..5) adds one at every clock edge where its selected source is high and no clear is written to it. The new value is visible on `rd_data` right after that edge.
- R4: A write of any data to index 26+i clears only that counter. When a clear and an event land in the same cycle, the clear wins and the counter reads zero.
- R5: Bit 4*i of the select word (bits 0, 4, 8, 12, 16, 20) picks the source of counter 26+i: 0 selects the receive source and 1 the alternate source. No other bit of the select word changes any count.
- R6: With its select bit at 0, counters 26, 27, 28 and 29 count, in turn: the short preamble detect; the long preamble detect; the header strobe; and the header strobe AND header valid.
- R7: With its select bit at 0, counter 30 counts frame-check-done AND address match AND destination-is-self AND data-frame. Counter 31 counts the same condition ANDed with frame-check-ok. The address match is true when `sender_mac_lo` equals the index-7 target (e.g. MAC ..:b9:4c:b1:c1 matches 0xB94CB1C1).
- R8: With its select bit at 1, counters 26..31 count, in turn: TX start, TX done, RSSI-above-threshold, gain change, AGC lock and TX-needs-ACK.
- R9: The RSSI event fires for one cycle when `rssi` (unsigned) becomes strictly greater than the threshold. It does not fire again until the compare has first gone false. An RSSI equal to the threshold is not above it.
- R10: A counter that reaches 2^CNT_W-1 holds that value on further events until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Register index for reads |
| rd_data | output | 32 | Combinational read data |
| short_pre_det | input | 1 | Short preamble detected strobe |
| long_pre_det | input | 1 | Long preamble detected strobe |
| hdr_strobe | input | 1 | Header decode strobe |
| hdr_valid | input | 1 | Header decoded as valid |
| fcs_done | input | 1 | Frame check finished strobe |
| fcs_ok | input | 1 | Frame check passed |
| sender_mac_lo | input | 32 | Low 32 bits of sender MAC address |
| dest_is_self | input | 1 | Destination address is this station |
| frame_is_data | input | 1 | Frame type is data |
| rssi | input | RSSI_W (16) | Current RSSI sample |
| gain_change | input | 1 | Gain change strobe |
| agc_lock | input | 1 | AGC lock strobe |
| tx_start | input | 1 | Transmit start strobe |
| tx_done | input | 1 | Transmit done strobe |
| tx_need_ack | input | 1 | Transmitted frame needs ACK strobe |

## Verification
The counter assertions assume that every strobe input is a clean synchronous level, sampled once per edge, with no X after reset. The saturation and increment properties also assume that a clear can only arrive through the write port. The bench therefore drives all inputs on the falling edge and returns them to idle between vectors. For the RSSI edge property, the bench keeps the idle RSSI below the programmed threshold, so each vector makes a fresh rising crossing. It builds the saturation case with a narrow counter width, so the limit is reached in a few dozen events.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;

    localparam int DATA_W     = 32;
    localparam int IDX_W      = 6;
    localparam int NUM_CNT    = 6;
    localparam int SEL_STRIDE = 4;

    localparam logic [IDX_W-1:0] IDX_ADDR_TGT = 6'd7;
    localparam logic [IDX_W-1:0] IDX_RSSI_THR = 6'd9;
    localparam logic [IDX_W-1:0] IDX_SRC_SEL  = 6'd19;
    localparam logic [IDX_W-1:0] IDX_CNT_BASE = 6'd26;

    typedef enum logic [0:0] {
        SRC_RX  = 1'b0,
        SRC_ALT = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic short_pre;
        logic long_pre;
        logic hdr_strobe;
        logic hdr_valid;
        logic fcs_done;
        logic fcs_ok;
        logic dest_self;
        logic is_data;
        logic gain_change;
        logic agc_lock;
        logic tx_start;
        logic tx_done;
        logic tx_need_ack;
    } phy_flags_t;

    typedef struct packed {
        logic [NUM_CNT-1:0] src_alt;
        logic [NUM_CNT-1:0] src_rx;
    } evt_pair_t;

    function automatic int sel_pos(int i);
        return i * SEL_STRIDE;
    endfunction

    function automatic logic [IDX_W-1:0] cnt_idx(int i);
        return IDX_CNT_BASE + IDX_W'(i);
    endfunction

endpackage

// File: rtl/evc_cfg_regs.sv
`timescale 1ns/1ps
module evc_cfg_regs
    import evc_pkg::*;
#(
    parameter int RSSI_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] addr_tgt,
    output logic [RSSI_W-1:0] rssi_thr,
    output logic [DATA_W-1:0] src_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_tgt <= '0;
            rssi_thr <= '0;
            src_sel  <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_ADDR_TGT: addr_tgt <= wr_data;
                IDX_RSSI_THR: rssi_thr <= wr_data[RSSI_W-1:0];
                IDX_SRC_SEL:  src_sel  <= wr_data;
                default: ;
            endcase
        end
    end

    p_tgt_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_ADDR_TGT) |=> addr_tgt == $past(wr_data));

    p_sel_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_SRC_SEL) |=> src_sel == $past(wr_data));

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == IDX_SRC_SEL) |=> $stable(src_sel));

endmodule

// File: rtl/evc_event_src.sv
`timescale 1ns/1ps
module evc_event_src
    import evc_pkg::*;
#(
    parameter int RSSI_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phy_flags_t        flags,
    input  logic [DATA_W-1:0] sender_lo,
    input  logic [DATA_W-1:0] addr_tgt,
    input  logic [RSSI_W-1:0] rssi,
    input  logic [RSSI_W-1:0] rssi_thr,
    output evt_pair_t         ev
);

    logic addr_match;
    logic frame_for_me;
    logic rssi_above;
    logic rssi_above_q;
    logic rssi_rise;

    assign addr_match   = (sender_lo == addr_tgt);
    assign frame_for_me = flags.fcs_done & addr_match & flags.dest_self & flags.is_data;
    assign rssi_above   = (rssi > rssi_thr);
    assign rssi_rise    = rssi_above & ~rssi_above_q;

    always_ff @(posedge clk) begin
        if (rst) rssi_above_q <= 1'b0;
        else     rssi_above_q <= rssi_above;
    end

    always_comb begin
        ev.src_rx[0]  = flags.short_pre;
        ev.src_rx[1]  = flags.long_pre;
        ev.src_rx[2]  = flags.hdr_strobe;
        ev.src_rx[3]  = flags.hdr_strobe & flags.hdr_valid;
        ev.src_rx[4]  = frame_for_me;
        ev.src_rx[5]  = frame_for_me & flags.fcs_ok;
        ev.src_alt[0] = flags.tx_start;
        ev.src_alt[1] = flags.tx_done;
        ev.src_alt[2] = rssi_rise;
        ev.src_alt[3] = flags.gain_change;
        ev.src_alt[4] = flags.agc_lock;
        ev.src_alt[5] = flags.tx_need_ack;
    end

    p_rssi_once_r9: assert property (@(posedge clk) disable iff (rst)
        rssi_rise |=> !rssi_rise);

    p_crc_subset_r7: assert property (@(posedge clk) disable iff (rst)
        ev.src_rx[5] |-> ev.src_rx[4]);

endmodule

// File: rtl/evc_sat_counter.sv
`timescale 1ns/1ps
module evc_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ev,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (ev && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && ev && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ev) |=> $stable(cnt));

endmodule

// File: rtl/evt_counter_bank.sv
`timescale 1ns/1ps
module evt_counter_bank
    import evc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int RSSI_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        rd_idx,
    output logic [31:0]       rd_data,
    input  logic              short_pre_det,
    input  logic              long_pre_det,
    input  logic              hdr_strobe,
    input  logic              hdr_valid,
    input  logic              fcs_done,
    input  logic              fcs_ok,
    input  logic [31:0]       sender_mac_lo,
    input  logic              dest_is_self,
    input  logic              frame_is_data,
    input  logic [RSSI_W-1:0] rssi,
    input  logic              gain_change,
    input  logic              agc_lock,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              tx_need_ack
);

    phy_flags_t        flags;
    evt_pair_t         ev;
    logic [DATA_W-1:0] addr_tgt;
    logic [RSSI_W-1:0] rssi_thr;
    logic [DATA_W-1:0] src_sel;
    logic [NUM_CNT-1:0] ev_sel;
    logic [NUM_CNT-1:0] clr;
    logic [CNT_W-1:0]  cnt [NUM_CNT];

    always_comb begin
        flags.short_pre   = short_pre_det;
        flags.long_pre    = long_pre_det;
        flags.hdr_strobe  = hdr_strobe;
        flags.hdr_valid   = hdr_valid;
        flags.fcs_done    = fcs_done;
        flags.fcs_ok      = fcs_ok;
        flags.dest_self   = dest_is_self;
        flags.is_data     = frame_is_data;
        flags.gain_change = gain_change;
        flags.agc_lock    = agc_lock;
        flags.tx_start    = tx_start;
        flags.tx_done     = tx_done;
        flags.tx_need_ack = tx_need_ack;
    end

    evc_cfg_regs #(.RSSI_W(RSSI_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .addr_tgt (addr_tgt),
        .rssi_thr (rssi_thr),
        .src_sel  (src_sel)
    );

    evc_event_src #(.RSSI_W(RSSI_W)) u_src (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .sender_lo (sender_mac_lo),
        .addr_tgt  (addr_tgt),
        .rssi      (rssi),
        .rssi_thr  (rssi_thr),
        .ev        (ev)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        src_sel_e pick;
        assign pick      = src_sel_e'(src_sel[sel_pos(g)]);
        assign ev_sel[g] = (pick == SRC_ALT) ? ev.src_alt[g] : ev.src_rx[g];
        assign clr[g]    = wr_en && (wr_idx == cnt_idx(g));

        evc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr[g]),
            .ev  (ev_sel[g]),
            .cnt (cnt[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_ADDR_TGT)
            rd_data = addr_tgt;
        else if (rd_idx == IDX_RSSI_THR)
            rd_data = DATA_W'(rssi_thr);
        else if (rd_idx == IDX_SRC_SEL)
            rd_data = src_sel;
        else begin
            for (int i = 0; i < NUM_CNT; i++)
                if (rd_idx == cnt_idx(i))
                    rd_data = DATA_W'(cnt[i]);
        end
    end

    p_clear_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

endmodule

// File: tb/sim_evt_counter_bank.sv
`timescale 1ns/1ps
module sim_evt_counter_bank;

    localparam int CNT_W = 6;
    localparam logic [31:0] TGT = 32'hB94CB1C1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [5:0] wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [5:0] rd_idx = '0;
    logic [31:0] rd_data;
    logic short_pre_det = 0, long_pre_det = 0, hdr_strobe = 0, hdr_valid = 0;
    logic fcs_done = 0, fcs_ok = 0, dest_is_self = 0, frame_is_data = 0;
    logic [31:0] sender_mac_lo = '0;
    logic [15:0] rssi = '0;
    logic gain_change = 0, agc_lock = 0, tx_start = 0, tx_done = 0, tx_need_ack = 0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    evt_counter_bank #(.CNT_W(CNT_W), .RSSI_W(16)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .short_pre_det(short_pre_det), .long_pre_det(long_pre_det),
        .hdr_strobe(hdr_strobe), .hdr_valid(hdr_valid),
        .fcs_done(fcs_done), .fcs_ok(fcs_ok), .sender_mac_lo(sender_mac_lo),
        .dest_is_self(dest_is_self), .frame_is_data(frame_is_data), .rssi(rssi),
        .gain_change(gain_change), .agc_lock(agc_lock), .tx_start(tx_start),
        .tx_done(tx_done), .tx_need_ack(tx_need_ack)
    );

    // stimulus bits
    localparam logic [14:0] M_SHORT = 15'h0001, M_LONG = 15'h0002, M_HSTR = 15'h0004,
                            M_HOK = 15'h0008, M_FDONE = 15'h0010, M_FOK = 15'h0020,
                            M_MATCH = 15'h0040, M_SELF = 15'h0080, M_DATA = 15'h0100,
                            M_RSSI = 15'h0200, M_GAIN = 15'h0400, M_AGC = 15'h0800,
                            M_TXS = 15'h1000, M_TXD = 15'h2000, M_ACK = 15'h4000;

    typedef struct packed {
        logic [5:0]  sel;
        logic [14:0] stim;
        logic [5:0]  exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{6'h00, M_SHORT, 6'h01},                                   // R6
        '{6'h00, M_LONG, 6'h02},                                    // R6
        '{6'h00, M_HSTR, 6'h04},                                    // R6
        '{6'h00, M_HSTR | M_HOK, 6'h0C},                            // R6
        '{6'h00, M_HOK, 6'h00},                                     // R6
        '{6'h00, M_FDONE | M_MATCH | M_SELF | M_DATA, 6'h10},       // R7
        '{6'h00, M_FDONE | M_FOK | M_MATCH | M_SELF | M_DATA, 6'h30}, // R7
        '{6'h00, M_FDONE | M_FOK | M_SELF | M_DATA, 6'h00},         // R7 no match
        '{6'h00, M_FDONE | M_FOK | M_MATCH | M_SELF, 6'h00},        // R7 not data
        '{6'h00, M_FOK | M_MATCH | M_SELF | M_DATA, 6'h00},         // R7 no done
        '{6'h3F, M_TXS, 6'h01},                                     // R8
        '{6'h3F, M_TXD, 6'h02},                                     // R8
        '{6'h3F, M_RSSI, 6'h04},                                    // R8 R9
        '{6'h3F, M_GAIN, 6'h08},                                    // R8
        '{6'h3F, M_AGC, 6'h10},                                     // R8
        '{6'h3F, M_ACK, 6'h20},                                     // R8
        '{6'h3F, 15'h01FF, 6'h00},                                  // R5
        '{6'h00, 15'h7E00, 6'h00},                                  // R5
        '{6'h15, 15'h7FFF, 6'h3F},                                  // R5
        '{6'h2A, 15'h7FFF, 6'h3F}                                   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] v);
        @(negedge clk);
        rd_idx = idx;
        #1 v = rd_data;
    endtask

    task automatic drive(input logic [14:0] s);
        short_pre_det = s[0];  long_pre_det = s[1];  hdr_strobe = s[2];
        hdr_valid = s[3];      fcs_done = s[4];      fcs_ok = s[5];
        sender_mac_lo = s[6] ? TGT : (TGT ^ 32'h1);
        dest_is_self = s[7];   frame_is_data = s[8];
        rssi = s[9] ? 16'd200 : 16'd50;
        gain_change = s[10];   agc_lock = s[11];     tx_start = s[12];
        tx_done = s[13];       tx_need_ack = s[14];
    endtask

    function automatic logic [31:0] spread(input logic [5:0] s);
        logic [31:0] r = 32'h0EEEEEE;  // non-select bits set, must not matter (R5)
        for (int i = 0; i < 6; i++) r[4*i] = s[i];
        return r;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #1ms;
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (VECS[k]) ;
        rd(6'd7, v);  check("R1 tgt reset", v, 0);
        rd(6'd9, v);  check("R1 thr reset", v, 0);
        rd(6'd19, v); check("R1 sel reset", v, 0);
        for (int i = 0; i < 6; i++) begin
            rd(6'd26 + 6'(i), v); check("R1 counter reset", v, 0);
        end
        rd(6'd0, v);  check("R1 unmapped 0", v, 0);
        rd(6'd40, v); check("R1 unmapped 40", v, 0);

        // R2 configuration
        wr(6'd9, 32'h12340064);
        rd(6'd9, v); check("R2 thr low bits", v, 32'h64);
        drive('0);
        wr(6'd7, TGT);
        rd(6'd7, v); check("R2 target", v, TGT);
        wr(6'd19, 32'hA5A5A5A5);
        rd(6'd19, v); check("R2 select word", v, 32'hA5A5A5A5);
        rd(6'd12, v); check("R1 unmapped 12", v, 0);

        // table walk: R5 R6 R7 R8
        for (int n = 0; n < NV; n++) begin
            for (int i = 0; i < 6; i++) wr(6'd26 + 6'(i), 32'hDEADBEEF);
            wr(6'd19, spread(VECS[n].sel));
            @(negedge clk); drive(VECS[n].stim);
            @(negedge clk); drive('0);
            for (int i = 0; i < 6; i++) begin
                rd(6'd26 + 6'(i), v);
                check($sformatf("R5/R6/R7/R8 vec%0d cnt%0d", n, 26 + i), v, {31'd0, VECS[n].exp[i]});
            end
        end

        // R3 multiple counts, R4 clear isolation and priority
        wr(6'd19, 32'h0);
        wr(6'd26, 0); wr(6'd27, 0);
        @(negedge clk); drive(M_SHORT | M_LONG);
        repeat (3) @(negedge clk);
        drive('0);
        rd(6'd26, v); check("R3 three events", v, 3);
        @(negedge clk); drive(M_LONG);
        wr_en = 1'b1; wr_idx = 6'd27; wr_data = 32'h5555;
        @(negedge clk); wr_en = 1'b0; drive('0);
        rd(6'd27, v); check("R4 clear beats event", v, 0);
        rd(6'd26, v); check("R4 other counter kept", v, 3);

        // R9 RSSI edge
        wr(6'd19, 32'h0000_0100);
        wr(6'd28, 0);
        @(negedge clk); drive(M_RSSI);
        repeat (5) @(negedge clk);
        drive('0);
        repeat (2) @(negedge clk);
        drive(M_RSSI);
        @(negedge clk); drive('0);
        rd(6'd28, v); check("R9 once per crossing", v, 2);
        @(negedge clk); rssi = 16'd100;
        repeat (3) @(negedge clk);
        rssi = 16'd50;
        rd(6'd28, v); check("R9 equal not above", v, 2);

        // R10 saturation
        wr(6'd19, 32'h0);
        wr(6'd26, 0);
        @(negedge clk); drive(M_SHORT);
        repeat (70) @(negedge clk);
        drive('0);
        rd(6'd26, v); check("R10 saturates", v, 63);
        wr(6'd26, 32'hFFFFFFFF);
        rd(6'd26, v); check("R4 clear after saturate", v, 0);

        // R1 mid-run reset
        wr(6'd19, 32'h7);
        @(negedge clk); drive(M_SHORT);
        @(negedge clk); drive('0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(6'd19, v); check("R1 sel after reset", v, 0);
        rd(6'd26, v); check("R1 count after reset", v, 0);

        summary();
    end

endmodule